// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the timing strobes for the multiplexed external memory bus of an 8-bit microcontroller. A machine cycle lasts twelve oscillator clocks and is divided into six states of two clocks each. A free-running position counter walks through the cycle. From that position and from a set of per-cycle request flags, the block produces four strobes: an active-high address latch strobe, an active-low program fetch strobe, and active-low read and write strobes for external data memory. It also chooses what the high address port carries, either the upper byte of the current address or the contents of the port register.

The instruction decoder supplies the request flags: external execution, an external data read or write, the width of the data pointer, the latch-strobe disable bit and a table-fetch flag. The block samples these flags once per machine cycle and holds them for the whole cycle. Every output is taken straight from a flip-flop, so the outputs are free of glitches.

Top module: `busStrobeGen`

## Requirements
- R1: While `rst` is high, `ale`=0, `psenN`=1, `rdN`=1, `wrN`=1, `hiSel`=0 and `p2Out`=0. The position counter starts at 0 in the clock period in which `rst` falls. The counter advances by one on every rising edge and wraps from 11 to 0.
- R2: When the latch strobe is enabled and the cycle has no data access, `ale` is 1 at positions 1, 2, 7 and 8, and 0 at every other position.
- R3: When `aleOff`=1, `ale` stays 0 for the whole cycle. Any one of these re-enables it: `extExec`=1, a data access in the cycle, or `tableFetch`=1.
- R4: In a cycle with a data access, the first latch pulse (positions 1 and 2) is dropped. The second pulse (positions 7 and 8) is still emitted.
- R5: When `extExec`=1 and the cycle has no data access, `psenN` is 0 at positions 4, 5, 6, 10 and 11, and 1 at every other position. When `extExec`=0, `psenN` stays 1.
- R6: In a cycle with a data access, `psenN` stays 1 at every position.
- R7: In a read cycle, `rdN` is 0 at positions 0 through 5. In a write cycle, `wrN` is 0 at the same positions. If a cycle requests both a read and a write, only the read strobe is driven.
- R8: The request flags are sampled only at the rising edge that enters position 0, so their values at position 11 govern the next cycle. A change to the flags at any other position has no effect on the strobes until the next cycle starts.
- R9: `hiSel`=1 and `p2Out` carries `addrHi` when either condition holds: `extExec`=1 and the cycle has no 8-bit-pointer data access, or the cycle has a 16-bit-pointer data access. `p2Out` is registered, so it shows the value `addrHi` had in the previous clock.
- R10: In an 8-bit-pointer data access cycle (`widePtr`=0), `hiSel`=0 and `p2Out` holds, for all 12 positions, the value `p2Reg` had at position 11 of the cycle before.
- R11: In any other cycle, `hiSel`=0 and `p2Out` shows the value `p2Reg` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| extExec | input | 1 | Code is being fetched from external program memory |
| dataRd | input | 1 | This cycle performs an external data read |
| dataWr | input | 1 | This cycle performs an external data write |
| widePtr | input | 1 | The data access uses a 16-bit pointer (0 = 8-bit pointer) |
| aleOff | input | 1 | Latch strobe disable bit |
| tableFetch | input | 1 | A code-table read instruction is executing |
| addrHi | input | 8 | Upper byte of the current bus address |
| p2Reg | input | 8 | Contents of the port-2 register |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program fetch read strobe, active low |
| rdN | output | 1 | External data read strobe, active low |
| wrN | output | 1 | External data write strobe, active low |
| hiSel | output | 1 | High port carries the address byte |
| p2Out | output | 8 | Value driven on the high address port |

## Verification
The bench first runs directed cycles that try each kind of cycle on its own: internal execution, external fetch, latch disabled with and without each override, 8-bit and 16-bit reads and writes, and a read and write requested together. These separate pulse dropping from the enable rules. In the directed cycles the flags change at mid-cycle, which shows whether they are sampled only at the cycle boundary. Random cycles then change the flags at random positions. `addrHi` and `p2Reg` change on every clock, so a register output that does not hold its value, or that samples at the wrong edge, shows up at once.

// File: rtl/busStrobePkg.sv
package busStrobePkg;

  // Flags captured once per machine cycle
  typedef struct packed {
    logic ext;
    logic rd;
    logic wr;
    logic wide;
    logic aleOff;
    logic tbl;
  } cycFlagsT;

  // Strobe values for the position being entered, control -> datapath
  typedef struct packed {
    logic ale;
    logic psenN;
    logic rdN;
    logic wrN;
    logic selHi;
    logic narrow;
    logic cycleLoad;
  } strobeT;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busStrobePkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   extExec,
  input  logic   dataRd,
  input  logic   dataWr,
  input  logic   widePtr,
  input  logic   aleOff,
  input  logic   tableFetch,
  output strobeT strb
);

  localparam int CYCLE = STATES * PHASES;
  localparam int CW    = $clog2(CYCLE);
  localparam int HALF  = STATES / 2;

  localparam logic [CW-1:0] LAST      = CW'(CYCLE - 1);
  localparam logic [CW-1:0] ALE_A     = CW'(PHASES - 1);
  localparam logic [CW-1:0] ALE_A_END = CW'(2 * PHASES - 2);
  localparam logic [CW-1:0] ALE_B     = CW'(HALF * PHASES + PHASES - 1);
  localparam logic [CW-1:0] ALE_B_END = CW'(HALF * PHASES + 2 * PHASES - 2);
  localparam logic [CW-1:0] PSEN_A    = CW'(2 * PHASES);
  localparam logic [CW-1:0] PSEN_A_END= CW'(3 * PHASES);
  localparam logic [CW-1:0] PSEN_B    = CW'((STATES - 1) * PHASES);
  localparam logic [CW-1:0] DS_END    = CW'(HALF * PHASES);

  logic [CW-1:0] cnt, cntNext;
  logic          wrap;
  cycFlagsT      flags, flagsNext, curIn;
  logic          dataCyc, narrowCyc, aleEn, fetchWin, aleWinA, aleWinB;

  function automatic logic inWin(logic [CW-1:0] c, logic [CW-1:0] lo,
                                 logic [CW-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

  always_comb begin
    wrap    = (cnt == LAST);
    cntNext = wrap ? '0 : cnt + 1'b1;
    curIn   = '{ext: extExec, rd: dataRd, wr: dataWr, wide: widePtr,
                aleOff: aleOff, tbl: tableFetch};
    flagsNext = wrap ? curIn : flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      flags <= '0;
    end else begin
      cnt   <= cntNext;
      flags <= flagsNext;
    end
  end

  // Strobe decode for the position about to be entered
  always_comb begin
    dataCyc   = flagsNext.rd | flagsNext.wr;
    narrowCyc = dataCyc & ~flagsNext.wide;
    aleEn     = ~flagsNext.aleOff | flagsNext.ext | dataCyc | flagsNext.tbl;
    aleWinA   = inWin(cntNext, ALE_A, ALE_A_END);
    aleWinB   = inWin(cntNext, ALE_B, ALE_B_END);
    fetchWin  = inWin(cntNext, PSEN_A, PSEN_A_END) | inWin(cntNext, PSEN_B, LAST);

    strb.ale       = aleEn & (aleWinB | (~dataCyc & aleWinA));
    strb.psenN     = ~(flagsNext.ext & ~dataCyc & fetchWin);
    strb.rdN       = ~(flagsNext.rd & (cntNext < DS_END));
    strb.wrN       = ~(flagsNext.wr & ~flagsNext.rd & (cntNext < DS_END));
    strb.selHi     = (flagsNext.ext & ~narrowCyc) | (dataCyc & flagsNext.wide);
    strb.narrow    = narrowCyc;
    strb.cycleLoad = wrap;
  end

  // R1: counter never leaves the machine cycle
  a_r1_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R8: flags only move at the cycle boundary
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> $stable(flags));

endmodule

// File: rtl/busPortPath.sv
module busPortPath
  import busStrobePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [ADDR_W-1:0] p2Reg,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              hiSel,
  output logic [ADDR_W-1:0] p2Out
);

  logic [ADDR_W-1:0] heldP2, portNext;

  always_comb begin
    if (strb.selHi)       portNext = addrHi;
    else if (strb.narrow) portNext = strb.cycleLoad ? p2Reg : heldP2;
    else                  portNext = p2Reg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psenN  <= 1'b1;
      rdN    <= 1'b1;
      wrN    <= 1'b1;
      hiSel  <= 1'b0;
      p2Out  <= '0;
      heldP2 <= '0;
    end else begin
      ale    <= strb.ale;
      psenN  <= strb.psenN;
      rdN    <= strb.rdN;
      wrN    <= strb.wrN;
      hiSel  <= strb.selHi;
      p2Out  <= portNext;
      if (strb.cycleLoad) heldP2 <= p2Reg;
    end
  end

  // R2: a latch pulse is never a single clock
  a_r2_ale_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);

  // R5: latch and fetch strobes never overlap
  a_r5_ale_psen_excl: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psenN));

  // R6: no fetch strobe while a data strobe is active
  a_r6_psen_quiet: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> psenN);

  // R7: read and write strobes exclusive
  a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  // R10: port value frozen during an 8-bit-pointer access
  a_r10_p2_hold: assert property (@(posedge clk) disable iff (rst)
    ((!rdN || !wrN) && !hiSel && $past(!rdN || !wrN) && $past(!hiSel))
      |-> $stable(p2Out));

endmodule

// File: rtl/busStrobeGen.sv
module busStrobeGen
  import busStrobePkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              extExec,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic              widePtr,
  input  logic              aleOff,
  input  logic              tableFetch,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [ADDR_W-1:0] p2Reg,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              hiSel,
  output logic [ADDR_W-1:0] p2Out
);

  strobeT strb;

  busSeqCtrl #(.STATES(STATES), .PHASES(PHASES)) uCtrl (
    .clk(clk), .rst(rst), .extExec(extExec), .dataRd(dataRd),
    .dataWr(dataWr), .widePtr(widePtr), .aleOff(aleOff),
    .tableFetch(tableFetch), .strb(strb)
  );

  busPortPath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rst(rst), .strb(strb), .addrHi(addrHi), .p2Reg(p2Reg),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .hiSel(hiSel),
    .p2Out(p2Out)
  );

endmodule

// File: tb/sim_busStrobeGen.sv
module sim_busStrobeGen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extExec = 0, dataRd = 0, dataWr = 0, widePtr = 0, aleOff = 0, tableFetch = 0;
  logic [7:0] addrHi = 8'h00, p2Reg = 8'h00;
  logic ale, psenN, rdN, wrN, hiSel;
  logic [7:0] p2Out;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  string phaseTag = "";

  // model state
  int pos = 0;
  logic mExt = 0, mRd = 0, mWr = 0, mWide = 0, mOff = 0, mTbl = 0;
  logic [7:0] prevAddr = 0, prevP2 = 0, heldP2 = 0;

  always #4 clk = ~clk;

  busStrobeGen u0 (
    .clk(clk), .rst(rst), .extExec(extExec), .dataRd(dataRd), .dataWr(dataWr),
    .widePtr(widePtr), .aleOff(aleOff), .tableFetch(tableFetch),
    .addrHi(addrHi), .p2Reg(p2Reg), .ale(ale), .psenN(psenN), .rdN(rdN),
    .wrN(wrN), .hiSel(hiSel), .p2Out(p2Out)
  );

  task automatic cmp(string tag, string name, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s%s %s pos=%0d actual=%h expected=%h", phaseTag, tag, name, pos, act, exp);
    end
  endtask

  task automatic checkAll();
    logic dataC, narrowC, en, eAle, ePsenN, eRdN, eWrN, eSel;
    logic [7:0] eP2;
    string aleTag, p2Tag;
    dataC   = mRd | mWr;
    narrowC = dataC & ~mWide;
    en      = ~mOff | mExt | dataC | mTbl;
    eAle    = en && ((pos == 7 || pos == 8) || (!dataC && (pos == 1 || pos == 2)));
    ePsenN  = !(mExt && !dataC && (pos == 4 || pos == 5 || pos == 6 || pos == 10 || pos == 11));
    eRdN    = !(mRd && pos <= 5);
    eWrN    = !(mWr && !mRd && pos <= 5);
    eSel    = (mExt && !narrowC) || (dataC && mWide);
    eP2     = eSel ? prevAddr : (narrowC ? heldP2 : prevP2);
    aleTag  = dataC ? "R4" : (mOff ? "R3" : "R2");
    p2Tag   = narrowC ? "R10" : (eSel ? "R9" : "R11");
    vectors++;
    cmp(aleTag, "ale", {7'd0, ale}, {7'd0, eAle});
    cmp(dataC ? "R6" : "R5", "psenN", {7'd0, psenN}, {7'd0, ePsenN});
    cmp("R7", "rdN", {7'd0, rdN}, {7'd0, eRdN});
    cmp("R7", "wrN", {7'd0, wrN}, {7'd0, eWrN});
    cmp(p2Tag, "hiSel", {7'd0, hiSel}, {7'd0, eSel});
    cmp(p2Tag, "p2Out", p2Out, eP2);
  endtask

  // one clock: inputs already set for this interval, advance model, sample
  task automatic stepClock();
    int nextPos;
    addrHi = 8'($urandom);
    p2Reg  = 8'($urandom);
    nextPos = (pos == 11) ? 0 : pos + 1;
    if (nextPos == 0) begin
      mExt = extExec; mRd = dataRd; mWr = dataWr; mWide = widePtr;
      mOff = aleOff; mTbl = tableFetch; heldP2 = p2Reg;
    end
    prevAddr = addrHi;
    prevP2   = p2Reg;
    @(negedge clk);
    pos = nextPos;
    checkAll();
  endtask

  task automatic runCycle(logic [5:0] f, int chgPos);
    for (int j = 0; j < 12; j++) begin
      if (j == chgPos) {extExec, dataRd, dataWr, widePtr, aleOff, tableFetch} = f;
      stepClock();
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed));
    // R1: reset values
    repeat (3) @(negedge clk);
    vectors++;
    cmp("R1", "reset ale", {7'd0, ale}, 8'd0);
    cmp("R1", "reset psenN", {7'd0, psenN}, 8'd1);
    cmp("R1", "reset rdN", {7'd0, rdN}, 8'd1);
    cmp("R1", "reset wrN", {7'd0, wrN}, 8'd1);
    cmp("R1", "reset hiSel", {7'd0, hiSel}, 8'd0);
    cmp("R1", "reset p2Out", p2Out, 8'd0);
    rst = 1'b0;
    pos = 0;
    // directed, flags changed mid-cycle: R8
    // order {ext, rd, wr, wide, aleOff, tbl}
    phaseTag = "R8 ";
    runCycle(6'b000000, 6);  // internal idle (R2)
    runCycle(6'b100000, 6);  // external fetch (R5)
    runCycle(6'b000010, 6);  // latch disabled (R3)
    runCycle(6'b100010, 6);  // disabled, ext override (R3)
    runCycle(6'b000011, 6);  // disabled, table fetch override (R3)
    runCycle(6'b010010, 6);  // disabled, data override, narrow read (R3, R10)
    runCycle(6'b101100, 3);  // wide write while external (R9, R4)
    runCycle(6'b110000, 9);  // narrow read while external (R10, R6)
    runCycle(6'b011100, 2);  // read and write together (R7)
    runCycle(6'b000000, 11);
    runCycle(6'b000000, 0);
    phaseTag = "";
    // random cycles
    for (int c = 0; c < 300; c++) begin
      runCycle(6'($urandom), int'($urandom % 12));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule